// File: doc/BRIEF.md
# Layer Configuration Validator

This block reviews a proposed stack of up to four display layers before the stack is committed to the compositor. Each layer is described by an enable, a normalized depth slot, a format-alpha flag, an 8-bit global alpha, a YUV flag and a flag saying that the layer is routed through the scaling frontend. A platform bit states whether the hardware can blend alpha on the bottom-most layer. The block counts the layers with alpha, the YUV layers and the frontend-routed layers. It checks that the depth slots are valid. It then either rejects the stack with a reason code or accepts it and gives each layer the index of a blending pipe.

Control is a four-state machine. In `ST_IDLE` the block waits for `start`. On `start` (transition IDLE->CHECK) it latches all layer inputs. `ST_CHECK` evaluates every rule in one cycle. CHECK->DONE is taken when no layer is enabled or when a rule fails. CHECK->WALK is taken otherwise. `ST_WALK` visits depth slots 1 to N-1, one slot per cycle. At each slot a layer with alpha moves the running pipe index up by one, and the layer at that slot receives the running index. WALK->DONE follows the last slot. `ST_DONE` raises `done` for one cycle and always returns DONE->IDLE. The verdict stays on the outputs until the next accepted `start`.

Top module: `layer_cfg_checker`

## Requirements
- R1: During and right after reset, `done`, `accept` and `reject` are 0, and `reason` and every pipe field are 0.
- R2: A stack with no enabled layer is accepted with reason 0 and all pipe fields 0. No other rule is evaluated.
- R3: An enabled layer counts as having alpha when its format-alpha flag is 1 or when its global alpha is not all ones (255).
- R4: With the bottom-alpha platform bit at 0, more than one alpha layer gives reject with reason 1. With the bit at 1, the limit is two layers.
- R5: With the platform bit at 0, an enabled alpha layer at depth slot 0 gives reject with reason 2. With the bit at 1, such a layer is allowed.
- R6: More than one enabled YUV layer gives reject with reason 3.
- R7: More than one enabled frontend-routed layer gives reject with reason 4. Flags on disabled layers are not counted.
- R8: An enabled layer whose depth slot is not below the number of enabled layers, or two enabled layers that share a slot, give reject with reason 5.
- R9: When several rules fail, the lowest reason code is reported, in the order 1, 2, 3, 4, 5. An accepted stack reports reason 0.
- R10: On accept, the layer at slot 0 gets pipe 0. Walking up from slot 1, the pipe index rises by one at each alpha layer and is given to that layer. Disabled layers read pipe 0. Pipe field i sits at bits [2i+1:2i] of `lay_pipe`.
- R11: `done` is a single-cycle pulse. It rises one clock after the sampling `start` edge for an empty or rejected stack, and four clocks after it for an accepted non-empty stack. At `done`, exactly one of `accept` and `reject` is 1. The verdict holds until the next accepted `start`.
- R12: A `start` received while a check is in progress, or in the `done` cycle, is ignored. The running check completes on the stack latched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check, sampled in idle |
| low_alpha_ok | input | 1 | Platform can blend alpha on the bottom layer |
| lay_en | input | 4 | Per-layer enable |
| lay_z | input | 8 | Per-layer depth slot, 2 bits each |
| lay_fmt_alpha | input | 4 | Per-layer format carries alpha |
| lay_galpha | input | 32 | Per-layer global alpha, 8 bits each |
| lay_yuv | input | 4 | Per-layer YUV format |
| lay_fe | input | 4 | Per-layer routed through the frontend |
| done | output | 1 | One-cycle completion pulse |
| accept | output | 1 | Stack accepted |
| reject | output | 1 | Stack rejected |
| reason | output | 3 | Reason code, 0 when accepted |
| lay_pipe | output | 8 | Per-layer pipe index, 2 bits each |

## Verification
Once `start` is sampled at a rising edge, the verdict of an empty or rejected stack is due one edge later. The verdict of an accepted stack is due four edges later, because the walk takes three cycles after the check state. The bench model counts down that same latency from the sampling edge. It compares `done`, `accept`, `reject` and `reason` at every falling edge. It compares the pipe fields at every falling edge outside the walk, since they are only defined once the walk has finished. Every output is therefore checked in the cycle it is due and in each cycle it is held afterwards.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WALK  = 2'd2,
        ST_DONE  = 2'd3
    } lcc_state_e;

    // Order of the codes is the reporting priority.
    typedef enum logic [2:0] {
        RSN_OK        = 3'd0,
        RSN_ALPHA_CNT = 3'd1,
        RSN_ALPHA_LOW = 3'd2,
        RSN_YUV_CNT   = 3'd3,
        RSN_FE_CNT    = 3'd4,
        RSN_ZPOS      = 3'd5
    } lcc_reason_e;

endpackage

// File: rtl/lcc_tally.sv
module lcc_tally #(
    parameter int NL = 4,
    parameter int ZW = 2,
    parameter int AW = 8,
    parameter int CW = 3
) (
    input  logic [NL-1:0]    en,
    input  logic [NL-1:0]    fmt_alpha,
    input  logic [NL*AW-1:0] galpha,
    input  logic [NL-1:0]    yuv,
    input  logic [NL-1:0]    fe,
    input  logic [NL*ZW-1:0] zpos,
    output logic [NL-1:0]    alpha_vec,
    output logic [CW-1:0]    n_en,
    output logic [CW-1:0]    n_alpha,
    output logic [CW-1:0]    n_yuv,
    output logic [CW-1:0]    n_fe,
    output logic             low_alpha
);

    // A layer has alpha if its format says so or its global alpha is below opaque.
    for (genvar g = 0; g < NL; g++) begin : g_alpha
        assign alpha_vec[g] = en[g] & (fmt_alpha[g] | (galpha[g*AW +: AW] != {AW{1'b1}}));
    end

    always_comb begin
        n_en      = '0;
        n_alpha   = '0;
        n_yuv     = '0;
        n_fe      = '0;
        low_alpha = 1'b0;
        for (int i = 0; i < NL; i++) begin
            n_en    = n_en    + CW'(en[i]);
            n_alpha = n_alpha + CW'(alpha_vec[i]);
            n_yuv   = n_yuv   + CW'(en[i] & yuv[i]);
            n_fe    = n_fe    + CW'(en[i] & fe[i]);
            if (alpha_vec[i] && (zpos[i*ZW +: ZW] == '0))
                low_alpha = 1'b1;
        end
    end

endmodule

// File: rtl/lcc_zmap.sv
module lcc_zmap #(
    parameter int NL = 4,
    parameter int ZW = 2,
    parameter int IW = 2,
    parameter int CW = 3
) (
    input  logic [NL-1:0]    en,
    input  logic [NL*ZW-1:0] zpos,
    input  logic [CW-1:0]    n_en,
    output logic [NL*IW-1:0] slot_layer,
    output logic [NL-1:0]    slot_used,
    output logic             z_bad
);

    // Inverse map: for each depth slot, which layer sits there.
    for (genvar s = 0; s < NL; s++) begin : g_slot
        always_comb begin
            slot_used[s]             = 1'b0;
            slot_layer[s*IW +: IW]   = '0;
            for (int i = NL - 1; i >= 0; i--) begin
                if (en[i] && (int'(zpos[i*ZW +: ZW]) == s)) begin
                    slot_used[s]           = 1'b1;
                    slot_layer[s*IW +: IW] = IW'(i);
                end
            end
        end
    end

    // Slots must be dense below the enabled count and unique.
    always_comb begin
        z_bad = 1'b0;
        for (int i = 0; i < NL; i++) begin
            if (en[i] && (int'(zpos[i*ZW +: ZW]) >= int'(n_en)))
                z_bad = 1'b1;
            for (int j = i + 1; j < NL; j++) begin
                if (en[i] && en[j] && (zpos[i*ZW +: ZW] == zpos[j*ZW +: ZW]))
                    z_bad = 1'b1;
            end
        end
    end

endmodule

// File: rtl/layer_cfg_checker.sv
module layer_cfg_checker
    import lcc_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int GALPHA_W   = 8,
    parameter int ALPHA_BASE = 1,
    parameter int YUV_MAX    = 1,
    parameter int FE_MAX     = 1,
    localparam int ZW = $clog2(NUM_LAYERS),
    localparam int PW = $clog2(NUM_LAYERS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           low_alpha_ok,
    input  logic [NUM_LAYERS-1:0]          lay_en,
    input  logic [NUM_LAYERS*ZW-1:0]       lay_z,
    input  logic [NUM_LAYERS-1:0]          lay_fmt_alpha,
    input  logic [NUM_LAYERS*GALPHA_W-1:0] lay_galpha,
    input  logic [NUM_LAYERS-1:0]          lay_yuv,
    input  logic [NUM_LAYERS-1:0]          lay_fe,
    output logic                           done,
    output logic                           accept,
    output logic                           reject,
    output logic [2:0]                     reason,
    output logic [NUM_LAYERS*PW-1:0]       lay_pipe
);

    localparam int NL = NUM_LAYERS;
    localparam int IW = ZW;
    localparam int CW = $clog2(NUM_LAYERS + 1);

    lcc_state_e state, nxt;

    // Latched copy of the stack under review.
    logic [NL-1:0]          cap_en;
    logic [NL*ZW-1:0]       cap_z;
    logic [NL-1:0]          cap_fa;
    logic [NL*GALPHA_W-1:0] cap_ga;
    logic [NL-1:0]          cap_yuv;
    logic [NL-1:0]          cap_fe;
    logic                   cap_quirk;

    logic [NL-1:0] alpha_vec;
    logic [CW-1:0] n_en, n_alpha, n_yuv, n_fe;
    logic          low_alpha;
    logic [NL*IW-1:0] slot_layer;
    logic [NL-1:0]    slot_used;
    logic             z_bad;

    logic [IW-1:0] walk_idx;
    logic [PW-1:0] cur_pipe;

    lcc_tally #(.NL(NL), .ZW(ZW), .AW(GALPHA_W), .CW(CW)) u_tally (
        .en        (cap_en),
        .fmt_alpha (cap_fa),
        .galpha    (cap_ga),
        .yuv       (cap_yuv),
        .fe        (cap_fe),
        .zpos      (cap_z),
        .alpha_vec (alpha_vec),
        .n_en      (n_en),
        .n_alpha   (n_alpha),
        .n_yuv     (n_yuv),
        .n_fe      (n_fe),
        .low_alpha (low_alpha)
    );

    lcc_zmap #(.NL(NL), .ZW(ZW), .IW(IW), .CW(CW)) u_zmap (
        .en         (cap_en),
        .zpos       (cap_z),
        .n_en       (n_en),
        .slot_layer (slot_layer),
        .slot_used  (slot_used),
        .z_bad      (z_bad)
    );

    // Rule evaluation, first failing rule wins.
    logic        stack_empty;
    logic [CW-1:0] alpha_lim;
    lcc_reason_e chk_reason;

    assign stack_empty = (n_en == '0);
    assign alpha_lim   = CW'(ALPHA_BASE) + CW'(cap_quirk);

    always_comb begin
        if (n_alpha > alpha_lim)
            chk_reason = RSN_ALPHA_CNT;
        else if (!cap_quirk && low_alpha)
            chk_reason = RSN_ALPHA_LOW;
        else if (n_yuv > CW'(YUV_MAX))
            chk_reason = RSN_YUV_CNT;
        else if (n_fe > CW'(FE_MAX))
            chk_reason = RSN_FE_CNT;
        else if (z_bad)
            chk_reason = RSN_ZPOS;
        else
            chk_reason = RSN_OK;
    end

    // Walk datapath: layer at the current slot and its new pipe index.
    logic [IW-1:0] walk_layer;
    logic          walk_used;
    logic [PW-1:0] step_pipe;
    logic          walk_last;

    assign walk_layer = slot_layer[walk_idx*IW +: IW];
    assign walk_used  = slot_used[walk_idx];
    assign step_pipe  = cur_pipe + PW'(alpha_vec[walk_layer]);
    assign walk_last  = (walk_idx == IW'(NL - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_CHECK;
            ST_CHECK: nxt = (stack_empty || (chk_reason != RSN_OK)) ? ST_DONE : ST_WALK;
            ST_WALK:  if (walk_last) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            accept    <= 1'b0;
            reject    <= 1'b0;
            reason    <= '0;
            lay_pipe  <= '0;
            cap_en    <= '0;
            cap_z     <= '0;
            cap_fa    <= '0;
            cap_ga    <= '0;
            cap_yuv   <= '0;
            cap_fe    <= '0;
            cap_quirk <= 1'b0;
            walk_idx  <= '0;
            cur_pipe  <= '0;
        end else begin
            done <= (nxt == ST_DONE);
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cap_en    <= lay_en;
                        cap_z     <= lay_z;
                        cap_fa    <= lay_fmt_alpha;
                        cap_ga    <= lay_galpha;
                        cap_yuv   <= lay_yuv;
                        cap_fe    <= lay_fe;
                        cap_quirk <= low_alpha_ok;
                        accept    <= 1'b0;
                        reject    <= 1'b0;
                        reason    <= '0;
                        lay_pipe  <= '0;
                    end
                end
                ST_CHECK: begin
                    walk_idx <= IW'(1);
                    cur_pipe <= '0;
                    if (stack_empty) begin
                        accept <= 1'b1;
                    end else if (chk_reason != RSN_OK) begin
                        reject <= 1'b1;
                        reason <= chk_reason;
                    end
                end
                ST_WALK: begin
                    walk_idx <= walk_idx + IW'(1);
                    if (walk_used) begin
                        cur_pipe                       <= step_pipe;
                        lay_pipe[walk_layer*PW +: PW]  <= step_pipe;
                    end
                    if (walk_last)
                        accept <= 1'b1;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
    parameter int CW         = 3,
    parameter int ALPHA_BASE = 1,
    parameter int YUV_MAX    = 1,
    parameter int FE_MAX     = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          accept,
    input logic          reject,
    input logic [2:0]    reason,
    input logic [CW-1:0] n_alpha,
    input logic [CW-1:0] n_yuv,
    input logic [CW-1:0] n_fe,
    input logic          low_alpha,
    input logic          cap_quirk,
    input logic          z_bad
);

    AST_VERDICT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (accept ^ reject)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject)); // R11

    AST_ACCEPT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> (reason == 3'd0)); // R9

    AST_REJECT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reject) |-> ((reason >= 3'd1) && (reason <= 3'd5))); // R9

    AST_ALPHA_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> (n_alpha <= (CW'(ALPHA_BASE) + CW'(cap_quirk)))); // R4

    AST_LOW_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept && !cap_quirk) |-> !low_alpha); // R5

    AST_YUV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> (n_yuv <= CW'(YUV_MAX))); // R6

    AST_FE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> (n_fe <= CW'(FE_MAX))); // R7

    AST_ZPOS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> !z_bad); // R8

endmodule

bind layer_cfg_checker lcc_checker #(
    .CW         (CW),
    .ALPHA_BASE (ALPHA_BASE),
    .YUV_MAX    (YUV_MAX),
    .FE_MAX     (FE_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .accept    (accept),
    .reject    (reject),
    .reason    (reason),
    .n_alpha   (n_alpha),
    .n_yuv     (n_yuv),
    .n_fe      (n_fe),
    .low_alpha (low_alpha),
    .cap_quirk (cap_quirk),
    .z_bad     (z_bad)
);

// File: tb/layer_cfg_checker_tb.sv
module layer_cfg_checker_tb;

    localparam int NL = 4;
    localparam int ZW = 2;
    localparam int AW = 8;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic quirk = 1'b0;

    logic           t_en  [NL];
    logic [ZW-1:0]  t_z   [NL];
    logic           t_fa  [NL];
    logic [AW-1:0]  t_ga  [NL];
    logic           t_yuv [NL];
    logic           t_fe  [NL];

    logic [NL-1:0]    p_en, p_fa, p_yuv, p_fe;
    logic [NL*ZW-1:0] p_z;
    logic [NL*AW-1:0] p_ga;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            p_en[i]           = t_en[i];
            p_fa[i]           = t_fa[i];
            p_yuv[i]          = t_yuv[i];
            p_fe[i]           = t_fe[i];
            p_z[i*ZW +: ZW]   = t_z[i];
            p_ga[i*AW +: AW]  = t_ga[i];
        end
    end

    logic             done, accept, reject;
    logic [2:0]       reason;
    logic [NL*PW-1:0] lay_pipe;

    layer_cfg_checker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .low_alpha_ok  (quirk),
        .lay_en        (p_en),
        .lay_z         (p_z),
        .lay_fmt_alpha (p_fa),
        .lay_galpha    (p_ga),
        .lay_yuv       (p_yuv),
        .lay_fe        (p_fe),
        .done          (done),
        .accept        (accept),
        .reject        (reject),
        .reason        (reason),
        .lay_pipe      (lay_pipe)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    string tag   = "R1";

    // Reference model state.
    bit m_busy, m_done, m_acc, m_rej;
    int m_cnt, m_reason;
    int m_pipe [NL];
    bit e_acc, e_rej;
    int e_reason, e_lat;
    int e_pipe [NL];

    function automatic void evaluate();
        int ne, na, ny, nf, p;
        bit low, zb;
        bit al [NL];
        ne = 0; na = 0; ny = 0; nf = 0; low = 0; zb = 0;
        for (int i = 0; i < NL; i++) begin
            e_pipe[i] = 0;
            al[i] = t_en[i] && (t_fa[i] || (t_ga[i] != 8'hFF));
            if (t_en[i]) ne++;
            if (al[i]) na++;
            if (t_en[i] && t_yuv[i]) ny++;
            if (t_en[i] && t_fe[i]) nf++;
            if (al[i] && t_z[i] == 0) low = 1;
        end
        for (int i = 0; i < NL; i++) begin
            if (t_en[i] && int'(t_z[i]) >= ne) zb = 1;
            for (int j = 0; j < NL; j++)
                if (i != j && t_en[i] && t_en[j] && t_z[i] == t_z[j]) zb = 1;
        end
        e_acc = 0; e_rej = 0; e_reason = 0; e_lat = 1;
        if (ne == 0) begin
            e_acc = 1;
        end else begin
            if (na > (quirk ? 2 : 1))   e_reason = 1;
            else if (!quirk && low)     e_reason = 2;
            else if (ny > 1)            e_reason = 3;
            else if (nf > 1)            e_reason = 4;
            else if (zb)                e_reason = 5;
            if (e_reason != 0) begin
                e_rej = 1;
            end else begin
                e_acc = 1;
                e_lat = NL;
                p = 0;
                for (int s = 0; s < ne; s++)
                    for (int i = 0; i < NL; i++)
                        if (t_en[i] && int'(t_z[i]) == s) begin
                            if (s > 0 && al[i]) p++;
                            e_pipe[i] = p;
                        end
            end
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_acc = 0; m_rej = 0; m_cnt = 0; m_reason = 0;
            for (int i = 0; i < NL; i++) m_pipe[i] = 0;
        end else begin
            bit was_done;
            was_done = m_done;
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_acc = e_acc; m_rej = e_rej; m_reason = e_reason;
                    for (int i = 0; i < NL; i++) m_pipe[i] = e_pipe[i];
                end
            end else if (!was_done && start) begin
                evaluate();
                m_busy = 1; m_cnt = e_lat;
                m_acc = 0; m_rej = 0; m_reason = 0;
                for (int i = 0; i < NL; i++) m_pipe[i] = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(done == m_done, "R11", "done", int'(done), int'(m_done));
            chk(accept == m_acc, tag, "accept", int'(accept), int'(m_acc));
            chk(reject == m_rej, tag, "reject", int'(reject), int'(m_rej));
            chk(int'(reason) == m_reason, tag, "reason", int'(reason), m_reason);
            if (!m_busy)
                for (int i = 0; i < NL; i++)
                    chk(int'(lay_pipe[i*PW +: PW]) == m_pipe[i], tag, "pipe",
                        int'(lay_pipe[i*PW +: PW]), m_pipe[i]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL R11 watchdog: actual %0d expected %0d", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic clr_cfg();
        quirk = 0;
        for (int i = 0; i < NL; i++) begin
            t_en[i] = 0; t_z[i] = 0; t_fa[i] = 0; t_ga[i] = 8'hFF; t_yuv[i] = 0; t_fe[i] = 0;
        end
    endtask

    task automatic lay(input int i, input int z, input bit fa, input int ga, input bit yuv, input bit fe);
        t_en[i] = 1; t_z[i] = ZW'(z); t_fa[i] = fa; t_ga[i] = AW'(ga); t_yuv[i] = yuv; t_fe[i] = fe;
    endtask

    task automatic run(input string t);
        tag = t;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        repeat (NL + 3) @(negedge clk);
    endtask

    initial begin
        clr_cfg();
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!done && !accept && !reject, "R1", "flags", int'({done, accept, reject}), 0);
        chk(reason == 0 && lay_pipe == 0, "R1", "reason/pipe", int'({reason, lay_pipe}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!done && !accept && !reject && reason == 0 && lay_pipe == 0, "R1", "after release",
            int'({done, accept, reject}), 0);

        // R2: empty stack, junk flags on disabled layers
        clr_cfg(); t_fa[0] = 1; t_yuv[1] = 1; t_yuv[2] = 1; t_z[3] = 3;
        run("R2");

        // R10: four opaque layers, permuted slots
        clr_cfg(); lay(0, 2, 0, 255, 1, 0); lay(1, 0, 0, 255, 0, 1); lay(2, 3, 0, 255, 0, 0); lay(3, 1, 0, 255, 0, 0);
        run("R10");

        // R3/R10: format alpha at slot 2
        clr_cfg(); lay(0, 0, 0, 255, 0, 0); lay(1, 1, 0, 255, 0, 0); lay(2, 2, 1, 255, 0, 0); lay(3, 3, 0, 255, 0, 0);
        run("R3");

        // R3: global alpha 254 at slot 1 counts as alpha
        clr_cfg(); lay(3, 0, 0, 255, 0, 0); lay(0, 1, 0, 254, 0, 0); lay(1, 2, 0, 255, 0, 0);
        run("R3");

        // R4: two alpha layers without the platform bit
        clr_cfg(); lay(0, 0, 0, 255, 0, 0); lay(1, 1, 1, 255, 0, 0); lay(2, 2, 0, 17, 0, 0);
        run("R4");

        // R4/R10: two alpha layers at slots 1 and 3 with the platform bit
        clr_cfg(); quirk = 1; lay(0, 3, 1, 255, 0, 0); lay(1, 0, 0, 255, 0, 0); lay(2, 1, 0, 0, 0, 0); lay(3, 2, 0, 255, 0, 0);
        run("R4");

        // R4: three alpha layers even with the platform bit
        clr_cfg(); quirk = 1; lay(0, 0, 1, 255, 0, 0); lay(1, 1, 1, 255, 0, 0); lay(2, 2, 1, 255, 0, 0);
        run("R4");

        // R5: alpha at slot 0 rejected without the bit
        clr_cfg(); lay(2, 0, 0, 128, 0, 0); lay(1, 1, 0, 255, 0, 0);
        run("R5");

        // R5: same stack accepted with the bit, slot 0 keeps pipe 0
        clr_cfg(); quirk = 1; lay(2, 0, 0, 128, 0, 0); lay(1, 1, 0, 255, 0, 0); lay(0, 2, 1, 255, 0, 0);
        run("R5");

        // R6: two YUV layers
        clr_cfg(); lay(0, 0, 0, 255, 1, 0); lay(1, 1, 0, 255, 1, 0);
        run("R6");

        // R7: two frontend layers
        clr_cfg(); lay(0, 0, 0, 255, 0, 1); lay(3, 1, 0, 255, 0, 1);
        run("R7");

        // R7: frontend flag on a disabled layer is not counted
        clr_cfg(); lay(0, 0, 0, 255, 0, 1); lay(1, 1, 0, 255, 0, 0); t_fe[2] = 1;
        run("R7");

        // R8: duplicate slot
        clr_cfg(); lay(0, 0, 0, 255, 0, 0); lay(1, 1, 0, 255, 0, 0); lay(2, 1, 0, 255, 0, 0);
        run("R8");

        // R8: slot beyond the enabled count
        clr_cfg(); lay(0, 0, 0, 255, 0, 0); lay(1, 3, 0, 255, 0, 0);
        run("R8");

        // R9: alpha count, YUV and slot faults together report code 1
        clr_cfg(); lay(0, 0, 0, 255, 1, 0); lay(1, 1, 1, 255, 1, 0); lay(2, 1, 1, 255, 0, 1); lay(3, 3, 0, 255, 0, 1);
        run("R9");

        // R9: bottom alpha plus YUV and frontend faults report code 2
        clr_cfg(); lay(0, 0, 1, 255, 1, 1); lay(1, 1, 0, 255, 1, 1);
        run("R9");

        // R12: a second start while busy is ignored
        clr_cfg(); lay(0, 0, 0, 255, 0, 0); lay(1, 1, 1, 255, 0, 0); lay(2, 2, 0, 255, 0, 0);
        tag = "R12";
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        clr_cfg(); lay(0, 0, 1, 255, 1, 0); lay(1, 0, 0, 255, 1, 0);
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        repeat (NL + 3) @(negedge clk);

        // R12: start held through the done cycle launches only one new check
        clr_cfg(); lay(0, 1, 0, 255, 0, 0); lay(1, 0, 0, 255, 0, 0);
        tag = "R12";
        @(negedge clk) start = 1;
        repeat (NL + 2) @(negedge clk);
        start = 0;
        repeat (NL + 3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule